// File: doc/BRIEF.md
# Multimode Video Pixel Output Formatter

This block turns one stream of video samples into the word sequence that leaves the chip on a 20-bit pixel port. Each sample has three 10-bit channels: Y, Cb and Cr for component video, or G, B and R for graphics. Each sample also carries horizontal sync, vertical sync, field and data-enable strobes. A mode code chooses the packing. The options are one narrow interleaved luma/chroma bus of 8 or 10 bits, a split luma/chroma bus of 16 or 20 bits, or one of two double-data-rate packings. The double-data-rate packings place a word on each half of the pixel clock: 12-bit 4:4:4 RGB, or 8-bit 4:2:2.

The stream has no back-pressure. The port runs on the line-locked pixel clock, and a sample is accepted on every rising edge. In the single-bus modes the clock runs at twice the pixel rate, so the source holds each pixel for two clocks. The sync and enable strobes go through the same register stages as the data, so they stay aligned with the port words. A new mode code takes effect only at the start of a frame.

Top module: `vfmt_out`

## Requirements
- R1: While reset is high, pix_out, hs_out, vs_out and fde_out are all zero and the active mode is 0. Reset is synchronous.
- R2: Any input sample appears at the port two rising clock edges after it is captured. Its hs, vs and field/enable values appear on those same edges.
- R3: Modes 0 (8-bit) and 1 (10-bit) are single-bus modes. A word index counts up on every clock, modulo 4, and returns to 0 on the first clock with data enable high after a low. Index 0 sends Cb, index 1 sends Y, index 2 sends Cr and index 3 sends Y. Mode 1 puts the 10-bit value on P[19:10]. Mode 0 puts bits [9:2] on P[19:12]. All other bits are zero.
- R4: In mode 2 (16-bit), Y[9:2] is on P[19:12] and the chroma byte is on P[11:4], with P[3:0] zero. The chroma is Cb when the word index is even and Cr when it is odd.
- R5: In mode 3 (20-bit), Y is on P[19:10] and the chroma is on P[9:0]. Cb and Cr alternate as in R4.
- R6: In mode 4 (DDR RGB), each colour is channel bits [9:2]. While the clock is high, P[11:0] carries {G[3:0], B[7:0]}. While the clock is low, P[11:0] carries {R[7:0], G[7:4]}. P[19:12] is zero.
- R7: In mode 5 (DDR 4:2:2), P[19:12] carries chroma[9:2] while the clock is high and Y[9:2] while the clock is low. Cb and Cr alternate as in R4. All other bits are zero.
- R8: While data enable is low, the channels are replaced by blanking codes before packing: luma 0x040 and chroma 0x200 in 10-bit terms, which is 0x10 and 0x80 at 8 bits. In mode 4 all three channels are replaced by zero.
- R9: A mode code written to cfg_mode is loaded only on a clock where vs_in is high and was low on the clock before. It applies from that sample onward. At all other times the active mode holds.
- R10: fde_out carries the delayed data enable when cfg_fde_sel is 1 and the delayed field_in when it is 0.
- R11: Mode codes 6 and 7 drive the whole port to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 3 | Requested packing mode |
| cfg_fde_sel | input | 1 | 1: fde_out is data enable; 0: fde_out is field |
| de_in | input | 1 | Data enable of the incoming sample |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| field_in | input | 1 | Field flag |
| ch0_in | input | 10 | Y or G |
| ch1_in | input | 10 | Cb or B |
| ch2_in | input | 10 | Cr or R |
| pix_out | output | 20 | Pixel port |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| fde_out | output | 1 | Delayed field or data enable |

## Verification
Each mode is driven with lines of distinct ramps on the three channels, so a swapped channel, lane or Cb/Cr phase shows up as a wrong value. The lines are framed by blanking clocks, which separate the blanking substitution and the restart of the word index from the active data. In the DDR modes the port is sampled in both clock phases, which tells the high-phase word from the low-phase word. A mode code changed without a vertical sync rise, a field/enable select flipped during a line, and the undefined codes 6 and 7 each test one control path on its own.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int CH_W     = 10;
  localparam int NARROW_W = 8;
  localparam int PORT_W   = 2 * CH_W;
  localparam int IDX_W    = 2;
  localparam int MODE_W   = 3;
  localparam int DDR_W    = 12;

  localparam logic [MODE_W-1:0] MODE_SB8     = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SB10    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_DB16    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_DB20    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_DDR_RGB = 3'd4;
  localparam logic [MODE_W-1:0] MODE_DDR_YC  = 3'd5;

  localparam logic [CH_W-1:0] BLANK_LUMA   = 10'h040;
  localparam logic [CH_W-1:0] BLANK_CHROMA = 10'h200;

  typedef struct packed {
    logic              de;
    logic              hs;
    logic              vs;
    logic              fde;
    logic [IDX_W-1:0]  idx;
    logic [MODE_W-1:0] mode;
    logic [CH_W-1:0]   c0;
    logic [CH_W-1:0]   c1;
    logic [CH_W-1:0]   c2;
  } stage_t;
endpackage

// File: rtl/vfmt_capture.sv
module vfmt_capture
  import vfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_fde_sel,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              field_in,
  input  logic [CH_W-1:0]   ch0_in,
  input  logic [CH_W-1:0]   ch1_in,
  input  logic [CH_W-1:0]   ch2_in,
  output stage_t            st
);
  timeunit 1ns; timeprecision 100ps;

  logic line_start;
  logic frame_start;

  assign line_start  = de_in && !st.de;
  assign frame_start = vs_in && !st.vs;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st.de   <= de_in;
      st.hs   <= hs_in;
      st.vs   <= vs_in;
      st.fde  <= cfg_fde_sel ? de_in : field_in;
      st.idx  <= line_start ? '0 : st.idx + 1'b1;
      st.mode <= frame_start ? cfg_mode : st.mode;
      st.c0   <= ch0_in;
      st.c1   <= ch1_in;
      st.c2   <= ch2_in;
    end
  end

  // R9: mode only moves on a vertical sync rise
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(vs_in && !st.vs) |=> st.mode == $past(st.mode));

  // R3: inside an active run the word index steps by one
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (rst)
    (de_in && st.de) |=> st.idx == $past(st.idx) + 1'b1);
endmodule

// File: rtl/vfmt_pack.sv
module vfmt_pack
  import vfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stage_t            st,
  output logic [PORT_W-1:0] rise_q,
  output logic [PORT_W-1:0] fall_q,
  output logic              hs_o,
  output logic              vs_o,
  output logic              fde_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int PAD_N = PORT_W - NARROW_W;
  localparam int PAD_D = PORT_W - DDR_W;
  localparam int PAD_S = PORT_W - 2 * NARROW_W;

  logic [CH_W-1:0]     y, cb, cr, c_pair, c_single;
  logic [NARROW_W-1:0] y8, cb8, cr8, cp8, cs8;
  logic [PORT_W-1:0]   rise_d, fall_d;

  always_comb begin
    if (st.de) begin
      y = st.c0; cb = st.c1; cr = st.c2;
    end else if (st.mode == MODE_DDR_RGB) begin
      y = '0; cb = '0; cr = '0;
    end else begin
      y = BLANK_LUMA; cb = BLANK_CHROMA; cr = BLANK_CHROMA;
    end
    c_pair   = st.idx[0] ? cr : cb;
    c_single = st.idx[0] ? y : (st.idx[1] ? cr : cb);
    y8  = y[CH_W-1 -: NARROW_W];
    cb8 = cb[CH_W-1 -: NARROW_W];
    cr8 = cr[CH_W-1 -: NARROW_W];
    cp8 = c_pair[CH_W-1 -: NARROW_W];
    cs8 = c_single[CH_W-1 -: NARROW_W];
  end

  always_comb begin
    rise_d = '0;
    fall_d = '0;
    case (st.mode)
      MODE_SB8: begin
        rise_d = {cs8, {PAD_N{1'b0}}};
        fall_d = rise_d;
      end
      MODE_SB10: begin
        rise_d = {c_single, {CH_W{1'b0}}};
        fall_d = rise_d;
      end
      MODE_DB16: begin
        rise_d = {y8, cp8, {PAD_S{1'b0}}};
        fall_d = rise_d;
      end
      MODE_DB20: begin
        rise_d = {y, c_pair};
        fall_d = rise_d;
      end
      MODE_DDR_RGB: begin
        rise_d = {{PAD_D{1'b0}}, y8[3:0], cb8};
        fall_d = {{PAD_D{1'b0}}, cr8, y8[7:4]};
      end
      MODE_DDR_YC: begin
        rise_d = {cp8, {PAD_N{1'b0}}};
        fall_d = {y8, {PAD_N{1'b0}}};
      end
      default: begin
        rise_d = '0;
        fall_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      fde_o  <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      hs_o   <= st.hs;
      vs_o   <= st.vs;
      fde_o  <= st.fde;
    end
  end

  // R8: RGB blanking drives zero in both phases
  assert_rgb_blank_R8: assert property (@(posedge clk) disable iff (rst)
    (st.mode == MODE_DDR_RGB && !st.de) |=> (rise_q == '0 && fall_q == '0));

  // R4: single-rate modes present one word per clock
  assert_sdr_one_word_R4: assert property (@(posedge clk) disable iff (rst)
    (st.mode < MODE_DDR_RGB) |=> rise_q == fall_q);

  // R11: undefined mode codes leave the port quiet
  assert_bad_mode_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (st.mode > MODE_DDR_YC) |=> (rise_q == '0 && fall_q == '0));

  // R6: upper lanes idle in DDR RGB
  assert_rgb_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (st.mode == MODE_DDR_RGB) |=> (rise_q[PORT_W-1:DDR_W] == '0 && fall_q[PORT_W-1:DDR_W] == '0));
endmodule

// File: rtl/vfmt_ddr_mux.sv
module vfmt_ddr_mux
  import vfmt_pkg::*;
(
  input  logic              clk,
  input  logic [PORT_W-1:0] rise_q,
  input  logic [PORT_W-1:0] fall_q,
  output logic [PORT_W-1:0] pix
);
  timeunit 1ns; timeprecision 100ps;

  // high phase carries the word launched at the rising edge
  assign pix = clk ? rise_q : fall_q;
endmodule

// File: rtl/vfmt_out.sv
module vfmt_out
  import vfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cfg_mode,
  input  logic        cfg_fde_sel,
  input  logic        de_in,
  input  logic        hs_in,
  input  logic        vs_in,
  input  logic        field_in,
  input  logic [9:0]  ch0_in,
  input  logic [9:0]  ch1_in,
  input  logic [9:0]  ch2_in,
  output logic [19:0] pix_out,
  output logic        hs_out,
  output logic        vs_out,
  output logic        fde_out
);
  timeunit 1ns; timeprecision 100ps;

  stage_t            st;
  logic [PORT_W-1:0] rise_q, fall_q;

  vfmt_capture u_capture (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fde_sel(cfg_fde_sel),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in), .field_in(field_in),
    .ch0_in(ch0_in), .ch1_in(ch1_in), .ch2_in(ch2_in), .st(st)
  );

  vfmt_pack u_pack (
    .clk(clk), .rst(rst), .st(st), .rise_q(rise_q), .fall_q(fall_q),
    .hs_o(hs_out), .vs_o(vs_out), .fde_o(fde_out)
  );

  vfmt_ddr_mux u_mux (
    .clk(clk), .rise_q(rise_q), .fall_q(fall_q), .pix(pix_out)
  );

  // R2: syncs leave two edges after they enter
  assert_hs_align_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> hs_out == $past(hs_in, 2));

  assert_vs_align_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> vs_out == $past(vs_in, 2));
endmodule

// File: tb/sim_vfmt_out.sv
module sim_vfmt_out;
  timeunit 1ns; timeprecision 100ps;

  typedef struct packed {
    logic       de, hs, vs, fde;
    logic [1:0] idx;
    logic [2:0] mode;
    logic [9:0] y, cb, cr;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_fde_sel = 1'b1;
  logic        de_in = 0, hs_in = 0, vs_in = 0, field_in = 0;
  logic [9:0]  ch0_in = 0, ch1_in = 0, ch2_in = 0;
  logic [19:0] pix_out;
  logic        hs_out, vs_out, fde_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";
  rec_t rec_now, rec_old;

  always #2.5 clk = ~clk;

  vfmt_out u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fde_sel(cfg_fde_sel),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in), .field_in(field_in),
    .ch0_in(ch0_in), .ch1_in(ch1_in), .ch2_in(ch2_in),
    .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out), .fde_out(fde_out)
  );

  task automatic chk(input string tag, input string what, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %05h expected %05h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // expected port word from the requirements
  function automatic logic [19:0] expect_word(input rec_t r, input bit low_phase);
    logic [9:0] y, cb, cr, cp, cs;
    logic [7:0] y8, cb8, cr8;
    logic [19:0] w;
    if (r.de) begin y = r.y; cb = r.cb; cr = r.cr; end
    else if (r.mode == 3'd4) begin y = 0; cb = 0; cr = 0; end
    else begin y = 10'h040; cb = 10'h200; cr = 10'h200; end   // R8
    cp = r.idx[0] ? cr : cb;
    case (r.idx)
      2'd0: cs = cb;
      2'd2: cs = cr;
      default: cs = y;
    endcase
    y8 = y[9:2]; cb8 = cb[9:2]; cr8 = cr[9:2];
    case (r.mode)
      3'd0: w = {cs[9:2], 12'h000};
      3'd1: w = {cs, 10'h000};
      3'd2: w = {y8, cp[9:2], 4'h0};
      3'd3: w = {y, cp};
      3'd4: w = low_phase ? {8'h00, cr8, y8[7:4]} : {8'h00, y8[3:0], cb8};
      3'd5: w = low_phase ? {y8, 12'h000} : {cp[9:2], 12'h000};
      default: w = 20'h0;
    endcase
    return w;
  endfunction

  task automatic step(input logic de, hs, vs, fld, input logic [9:0] y, cb, cr);
    rec_t nxt;
    string ptag;
    de_in = de; hs_in = hs; vs_in = vs; field_in = fld;
    ch0_in = y; ch1_in = cb; ch2_in = cr;
    @(posedge clk);
    nxt.de = de; nxt.hs = hs; nxt.vs = vs;
    nxt.fde = cfg_fde_sel ? de : fld;
    nxt.idx = (de && !rec_now.de) ? 2'd0 : rec_now.idx + 2'd1;
    nxt.mode = (vs && !rec_now.vs) ? cfg_mode : rec_now.mode;
    nxt.y = y; nxt.cb = cb; nxt.cr = cr;
    rec_old = rec_now;
    rec_now = nxt;
    #1;
    ptag = (rec_old.de || cur_tag == "R11" || cur_tag == "R1") ? cur_tag : "R8";
    chk(ptag, "pix high phase", pix_out, expect_word(rec_old, 1'b0));
    chk("R2", "hs", {19'b0, hs_out}, {19'b0, rec_old.hs});
    chk("R2", "vs", {19'b0, vs_out}, {19'b0, rec_old.vs});
    chk(cur_tag == "R10" ? "R10" : "R2", "fde", {19'b0, fde_out}, {19'b0, rec_old.fde});
    #2;
    chk(ptag, "pix low phase", pix_out, expect_word(rec_old, 1'b1));
  endtask

  task automatic blank_clock(input logic hs);
    step(1'b0, hs, 1'b0, 1'b0, 10'h3ff, 10'h3ff, 10'h3ff);
  endtask

  task automatic new_frame(input logic [2:0] m);
    cfg_mode = m;
    step(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
  endtask

  task automatic line(input int n, input int base, input logic fld);
    blank_clock(1'b1);
    blank_clock(1'b0);
    for (int i = 0; i < n; i++)
      step(1'b1, 1'b0, 1'b0, fld ^ i[1], 10'(base + i * 7), 10'(base * 3 + i * 11 + 5), 10'(base + i * 13 + 100));
    blank_clock(1'b0);
    blank_clock(1'b0);
    blank_clock(1'b0);
  endtask

  task automatic test_reset;
    cur_tag = "R1";
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pix in reset", pix_out, 20'h0);
    chk("R1", "syncs in reset", {17'b0, hs_out, vs_out, fde_out}, 20'h0);
    rst = 1'b0;
    rec_now = '0;
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0);  // first word after reset: mode 0 blank chroma
  endtask

  task automatic test_single_bus;
    cur_tag = "R3";
    new_frame(3'd0); line(8, 40, 1'b0); line(5, 300, 1'b0);
    new_frame(3'd1); line(8, 513, 1'b0);
  endtask

  task automatic test_dual_bus;
    cur_tag = "R4"; new_frame(3'd2); line(7, 77, 1'b0);
    cur_tag = "R5"; new_frame(3'd3); line(7, 901, 1'b0);
  endtask

  task automatic test_ddr;
    cur_tag = "R6"; new_frame(3'd4); line(6, 222, 1'b0); line(4, 700, 1'b0);
    cur_tag = "R7"; new_frame(3'd5); line(6, 450, 1'b0);
  endtask

  task automatic test_blank;
    cur_tag = "R8";
    new_frame(3'd1);
    repeat (6) blank_clock(1'b0);
    new_frame(3'd4);
    repeat (4) blank_clock(1'b0);
  endtask

  task automatic test_mode_hold;
    cur_tag = "R9";
    new_frame(3'd2);
    cfg_mode = 3'd3;          // no vertical sync rise: mode 2 stays
    line(6, 130, 1'b0);
    cfg_mode = 3'd4;
    line(4, 260, 1'b0);
    new_frame(3'd3);          // now applies
    line(4, 390, 1'b0);
  endtask

  task automatic test_field_de;
    cur_tag = "R10";
    new_frame(3'd0);
    cfg_fde_sel = 1'b0;
    line(6, 55, 1'b1);
    cfg_fde_sel = 1'b1;
    line(4, 66, 1'b1);
  endtask

  task automatic test_bad_mode;
    cur_tag = "R11";
    new_frame(3'd6); line(4, 500, 1'b0);
    new_frame(3'd7); line(4, 600, 1'b0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    test_reset;
    test_single_bus;
    test_dual_bus;
    test_ddr;
    test_blank;
    test_mode_hold;
    test_field_de;
    test_bad_mode;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule